// File: doc/BRIEF.md
# Prescaled Interval Timer

This block raises a periodic interrupt for a processor core. It counts in two stages. A prescaler divides the core clock by a programmable scale value plus one. Each time the prescaler expires it sends a tick to a period counter. The period counter counts ticks down to zero. When a tick arrives while it already holds zero, the counter reloads from a period register and sends a single-cycle interrupt pulse. With scale S and period P, the interrupts therefore arrive every (S+1)·(P+1) core cycles.

Software sets the timer up through a simple write port. A two-bit select picks the scale, period or count register, and one select code is unused. An enable input runs or freezes the whole countdown. The live count can be read back at all times. Writes to the scale and period registers are picked up at the next reload of the matching stage. A write to the count replaces the count at once.

Top module: `interval_timer`

## Requirements
- R1: While rst_n is low, countOut is 0 and irq is 0. The scale, period and prescaler registers also reset to 0.
- R2: While enable is high, the prescaler produces one tick every scale+1 cycles, so the count steps at that rate.
- R3: On a tick with a nonzero count, the count decreases by exactly one. On a tick with a count of zero, the count reloads from the period register.
- R4: irq is high for exactly the one cycle after each zero-count reload, and is low at all other times.
- R5: While enable is low, the prescaler and the count hold their values, and irq stays low.
- R6: A write with wrSel = 2 loads wrData into the count on the next edge. This load overrides any decrement or reload in that same cycle, and no interrupt comes from that cycle.
- R7: With period 0 and the timer enabled, irq pulses on every prescaler tick. With scale 0, that means every cycle.
- R8: A write with wrSel = 0 stores wrData[7:0] as the scale. The prescaler takes the new value only when it next expires and reloads. A write with wrSel = 1 stores the period, which is used at the next zero-count reload.
- R9: A write with wrSel = 3 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the prescaler and the count when high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 scale, 1 period, 2 count, 3 none |
| wrData | input | 16 | Write data; scale uses the low 8 bits |
| countOut | output | 16 | Current count value |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The timer runs with all-zero settings, which checks that period zero gives back-to-back pulses. It then runs with a nonzero scale and period, where the spacing of ticks and interrupts separates a divide by scale+1 from a divide by scale. Enable is paused partway through a countdown, which shows whether both stages really freeze. Count writes are placed mid-run, a scale change is made while the prescaler is counting, and the unused select code is written. Each result is compared cycle by cycle against a reference model, which catches an early reload, a lost tick, or a write that leaks into the wrong register.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  typedef enum logic [1:0] {
    SEL_SCALE  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic tick;
    logic loadCount;
    logic reloadCount;
    logic decCount;
  } ctrlStrobe_t;

endpackage

// File: rtl/interval_timer_ctrl.sv
module interval_timer_ctrl
  import interval_timer_pkg::*;
#(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               wrCount,
  input  logic               countIsZero,
  input  logic [SCALE_W-1:0] scaleVal,
  output ctrlStrobe_t        strobe,
  output logic               irq
);

  logic [SCALE_W-1:0] prescaler;
  logic               preExpired;

  assign preExpired = (prescaler == '0);

  always_comb begin
    strobe             = '0;
    strobe.tick        = enable && preExpired;
    strobe.loadCount   = wrCount;
    strobe.reloadCount = strobe.tick && countIsZero && !wrCount;
    strobe.decCount    = strobe.tick && !countIsZero && !wrCount;
  end

  // first stage: reload from the scale register on expiry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescaler <= '0;
    end else if (enable) begin
      if (preExpired) prescaler <= scaleVal;
      else            prescaler <= prescaler - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= strobe.reloadCount;
  end

endmodule

// File: rtl/interval_timer_datapath.sv
module interval_timer_datapath
  import interval_timer_pkg::*;
#(
  parameter int SCALE_W = 8,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  regSel_e            wrSel,
  input  logic [COUNT_W-1:0] wrData,
  input  ctrlStrobe_t        strobe,
  output logic [SCALE_W-1:0] scaleVal,
  output logic [COUNT_W-1:0] countVal,
  output logic               countIsZero
);

  logic [COUNT_W-1:0] periodReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scaleVal  <= '0;
      periodReg <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_SCALE:  scaleVal  <= wrData[SCALE_W-1:0];
        SEL_PERIOD: periodReg <= wrData;
        default:    ;
      endcase
    end
  end

  // second stage: the direct load wins over the tick actions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  countVal <= '0;
    else if (strobe.loadCount)   countVal <= wrData;
    else if (strobe.reloadCount) countVal <= periodReg;
    else if (strobe.decCount)    countVal <= countVal - 1'b1;
  end

  assign countIsZero = (countVal == '0);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int SCALE_W = 8,
  parameter int COUNT_W = 16,
  localparam int SEL_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [COUNT_W-1:0] wrData,
  output logic [COUNT_W-1:0] countOut,
  output logic               irq
);

  ctrlStrobe_t        strobe;
  logic [SCALE_W-1:0] scaleVal;
  logic               countIsZero;
  logic               wrCount;
  regSel_e            selDec;

  assign selDec  = regSel_e'(wrSel);
  assign wrCount = wrEn && (selDec == SEL_COUNT);

  interval_timer_ctrl #(.SCALE_W(SCALE_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wrCount(wrCount),
    .countIsZero(countIsZero), .scaleVal(scaleVal),
    .strobe(strobe), .irq(irq)
  );

  interval_timer_datapath #(.SCALE_W(SCALE_W), .COUNT_W(COUNT_W)) dpath (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(selDec), .wrData(wrData),
    .strobe(strobe), .scaleVal(scaleVal), .countVal(countOut),
    .countIsZero(countIsZero)
  );

endmodule

// File: rtl/interval_timer_checks.sv
module interval_timer_checks #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               wrEn,
  input logic [1:0]         wrSel,
  input logic [COUNT_W-1:0] wrData,
  input logic [COUNT_W-1:0] countOut,
  input logic               irq
);

  logic primed;
  logic wrCnt;
  assign wrCnt = wrEn && (wrSel == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (countOut == '0 && !irq)));

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!enable) && $past(!wrCnt) |-> countOut == $past(countOut));

  assert_no_irq_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && irq |-> $past(enable));

  assert_irq_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed && irq |-> $past(countOut) == '0 && !$past(wrCnt));

  assert_direct_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(wrCnt) |-> countOut == $past(wrData));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(enable) && $past(!wrCnt) && $past(countOut) != '0
    |-> countOut == $past(countOut) || countOut == $past(countOut) - 1'b1);

endmodule

bind interval_timer interval_timer_checks #(.COUNT_W(COUNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wrEn(wrEn), .wrSel(wrSel),
  .wrData(wrData), .countOut(countOut), .irq(irq)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [15:0] wrData = '0;
  logic [15:0] countOut;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string curTag = "R1";

  always #4 clk = ~clk;   // 125 MHz

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .countOut(countOut), .irq(irq)
  );

  typedef struct packed { logic [15:0] cnt; logic irq; } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  // reference model built from the requirements
  logic [7:0]  mScale, mPre;
  logic [15:0] mPeriod, mCnt;
  logic        mIrq;

  always @(posedge clk) begin
    if (!rst_n) begin
      mScale = '0; mPre = '0; mPeriod = '0; mCnt = '0; mIrq = 1'b0;
    end else begin
      logic tick, wc;
      exp_t e;
      tick = enable && (mPre == 8'd0);
      wc   = wrEn && (wrSel == 2'd2);
      mIrq = tick && (mCnt == 16'd0) && !wc;
      if (enable) mPre = (mPre == 8'd0) ? mScale : mPre - 8'd1;
      if (wc)        mCnt = wrData;
      else if (tick) mCnt = (mCnt == 16'd0) ? mPeriod : mCnt - 16'd1;
      if (wrEn && wrSel == 2'd0) mScale  = wrData[7:0];
      if (wrEn && wrSel == 2'd1) mPeriod = wrData;
      e.cnt = mCnt; e.irq = mIrq;
      expQ.push_back(e);
      tagQ.push_back(curTag);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && expQ.size() > 0 && !done) begin
      exp_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (countOut !== e.cnt || irq !== e.irq) begin
        fails++;
        $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                 t, countOut, irq, e.cnt, e.irq);
      end
    end
  end

  task automatic drive(input logic en, input logic we, input logic [1:0] sel,
                       input logic [15:0] d, input int n, input string t);
    enable = en; wrEn = we; wrSel = sel; wrData = d; curTag = t;
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic en, input logic [1:0] sel,
                     input logic [15:0] d, input string t);
    drive(en, 1'b1, sel, d, 1, t);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (countOut !== 16'd0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1: count=%0d irq=%0b expected count=0 irq=0", countOut, irq);
    end
    rst_n = 1'b1;
    drive(1, 0, 2'd3, 0, 6, "R7");               // zero period, zero scale
    put(1, 2'd0, 16'h0003, "R8");                 // scale 3
    put(1, 2'd1, 16'd4, "R8");                    // period 4
    put(1, 2'd2, 16'd4, "R6");                    // count 4
    drive(1, 0, 2'd3, 0, 60, "R2");
    drive(1, 0, 2'd3, 0, 30, "R3");
    drive(1, 0, 2'd3, 0, 30, "R4");
    drive(0, 0, 2'd3, 0, 12, "R5");
    drive(1, 0, 2'd3, 0, 15, "R5");
    put(0, 2'd2, 16'd9, "R6");
    drive(0, 0, 2'd3, 0, 4, "R6");
    drive(1, 0, 2'd3, 0, 7, "R6");
    put(1, 2'd2, 16'd0, "R6");
    drive(1, 0, 2'd3, 0, 20, "R6");
    put(1, 2'd3, 16'h00FF, "R9");
    drive(1, 1, 2'd3, 16'h1234, 5, "R9");
    drive(1, 0, 2'd3, 0, 30, "R9");
    put(1, 2'd0, 16'h0001, "R8");                 // scale change mid-count
    drive(1, 0, 2'd3, 0, 40, "R8");
    put(1, 2'd1, 16'd0, "R7");
    drive(1, 0, 2'd3, 0, 20, "R7");
    put(1, 2'd0, 16'h0000, "R7");
    drive(1, 0, 2'd3, 0, 10, "R7");
    for (int k = 0; k < 6; k++) begin
      put(1, 2'd2, 16'(k * 3), "R6");
      drive(1, 0, 2'd3, 0, k + 1, "R6");
    end
    drive(1, 0, 2'd3, 0, 10, "R3");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule